// File: doc/BRIEF.md
# Writable Control Store Microsequencer

This block sequences microcode out of a writable control store of 1024 words of 48 bits. After reset a boot loader copies a fixed image into the store and into a 256-entry opcode dispatch table. Instruction fetch stays idle until that copy is complete. The sequencer then fetches one microinstruction per cycle. It presents the microinstruction to the datapath on `uinst_o` and chooses the next micro-address from one of four sources: the incremented micro-PC, a jump target, a conditional jump target, or the dispatch entry of the current macro-opcode.

A debug port works independently of the microprogram. It can stop execution at an instruction boundary and advance one microinstruction per step request. While stopped, `upc_o` and `uinst_o` show the address and the word that will execute next. The port can also rewrite control store and dispatch locations, and it can let the sequencer continue. Rewrites are only accepted while the sequencer is stopped. A rewrite attempted at any other time is dropped and reported.

Top module: `wcs_sequencer`

## Requirements
- R1: After reset is released, `load_done_o` and `uvalid_o` stay low for exactly 1280 clock cycles (1024 store words plus 256 dispatch entries). On the next cycle the sequencer is running, with `upc_o` = 0 and `uvalid_o` high.
- R2: The boot image has two parts. Store word a holds {13'h1A5, a, a, 3'b000, a+1, 2'b00}. Dispatch entry o holds the micro-address o*4.
- R3: Microinstruction bit fields are: [1:0] next-address select, [11:2] jump target, [14:12] condition select, [47:15] datapath payload. Select 00 moves to micro-PC+1, wrapping from 1023 to 0.
- R4: Select 01 moves to the jump target.
- R5: Select 10 moves to the jump target when `cond_i[condition select]` is 1, and to micro-PC+1 when it is 0.
- R6: Select 11 moves to the dispatch table entry addressed by `opcode_i`.
- R7: When `dbg_halt_req_i` is high while running, no microinstruction executes in that cycle (`uvalid_o` low). The next cycle shows `dbg_halted_o` high with the micro-PC unchanged. While halted with no step request, `upc_o` and `uinst_o` hold steady.
- R8: While halted, each cycle with `dbg_step_i` high and `dbg_resume_i` low executes exactly one microinstruction (`uvalid_o` high), and the sequencer stays halted afterwards.
- R9: While halted, `dbg_resume_i` returns the sequencer to running in the following cycle. It takes precedence over a step in the same cycle.
- R10: While halted, `dbg_wr_i` writes `dbg_wr_data_i` into the control store (`dbg_wr_sel_i` = 0) or writes its low 10 bits into the dispatch entry at `dbg_wr_addr_i[7:0]` (`dbg_wr_sel_i` = 1). The new contents are seen by the very next fetch, and `dbg_wr_err_o` stays low.
- R11: A `dbg_wr_i` that arrives while the sequencer is not halted changes nothing, and `dbg_wr_err_o` is high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cond_i | input | 8 | Condition bits from the datapath |
| opcode_i | input | 8 | Current macro-opcode used for dispatch |
| uinst_o | output | 48 | Microinstruction at the current micro-PC |
| upc_o | output | 10 | Current micro-PC |
| uvalid_o | output | 1 | The microinstruction on uinst_o executes this cycle |
| load_done_o | output | 1 | Boot image copy finished |
| dbg_halt_req_i | input | 1 | Stop at the next instruction boundary |
| dbg_step_i | input | 1 | Execute one microinstruction while halted |
| dbg_resume_i | input | 1 | Leave the halted state |
| dbg_halted_o | output | 1 | Sequencer is halted |
| dbg_wr_i | input | 1 | Debug write request |
| dbg_wr_sel_i | input | 1 | Write target: 0 control store, 1 dispatch table |
| dbg_wr_addr_i | input | 10 | Write address |
| dbg_wr_data_i | input | 48 | Write data |
| dbg_wr_err_o | output | 1 | Previous cycle's write was refused |

## Verification
The bench probes the last cycle of the boot copy. A loader that is off by one cycle starts fetching one cycle early or late, or runs its first instruction before the last dispatch entry exists. It patches the word at the halted micro-PC and checks that `uinst_o` changes at once. A store with a registered read would show the stale word there. It tests conditional jumps with the selected condition bit both set and cleared, wraps the micro-PC at the top of the store, and dispatches through a dispatch entry rewritten at runtime. A wrong condition mux or a dispatch table that still holds the boot image would then send the micro-PC to the wrong place. Finally, it issues a write while running and later jumps to the targeted address. A design that accepted the write would expose the changed word instead of the boot image.

// File: rtl/wcs_pkg.sv
package wcs_pkg;

   typedef enum logic [1:0] {
      NXT_INC  = 2'b00,
      NXT_JMP  = 2'b01,
      NXT_CJMP = 2'b10,
      NXT_DISP = 2'b11
   } nxt_sel_e;

   typedef enum logic {
      SEQ_RUN  = 1'b0,
      SEQ_HALT = 1'b1
   } seq_state_e;

   localparam int SEL_W      = 2;
   localparam int IMG_MARK_W = 13;
   localparam logic [IMG_MARK_W-1:0] IMG_MARK = 13'h1A5;

endpackage

// File: rtl/wcs_ram.sv
module wcs_ram #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 48
) (
   input  logic              clk_i,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] waddr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [ADDR_W-1:0] raddr_i,
   output logic [DATA_W-1:0] rdata_o
);
   localparam int DEPTH = 1 << ADDR_W;

   if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_depth
      $error("wcs_ram: ADDR_W out of range");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("wcs_ram: DATA_W must be positive");
   end

   logic [DATA_W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk_i) begin
      if (we_i) mem_q[waddr_i] <= wdata_i;
   end

   // combinational read: a rewritten word is visible on the next fetch
   assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/wcs_boot_loader.sv
module wcs_boot_loader
   import wcs_pkg::*;
#(
   parameter int UADDR_W = 10,
   parameter int UWORD_W = 48,
   parameter int OPC_W   = 8,
   parameter int CSEL_W  = 3
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   output logic               busy_o,
   output logic               cs_we_o,
   output logic [UADDR_W-1:0] cs_addr_o,
   output logic [UWORD_W-1:0] cs_data_o,
   output logic               dt_we_o,
   output logic [OPC_W-1:0]   dt_addr_o,
   output logic [UADDR_W-1:0] dt_data_o
);
   localparam int CS_DEPTH = 1 << UADDR_W;
   localparam int DT_DEPTH = 1 << OPC_W;
   localparam int TOTAL    = CS_DEPTH + DT_DEPTH;
   localparam int CNT_W    = $clog2(TOTAL) + 1;
   localparam int PAY_W    = UWORD_W - SEL_W - UADDR_W - CSEL_W;

   if (OPC_W > UADDR_W) begin : g_bad_opc
      $error("wcs_boot_loader: OPC_W must not exceed UADDR_W");
   end
   if (PAY_W < 1) begin : g_bad_pay
      $error("wcs_boot_loader: word too narrow for its fields");
   end

   function automatic logic [UWORD_W-1:0] image_word(input logic [UADDR_W-1:0] a);
      logic [PAY_W-1:0]   pay;
      logic [UADDR_W-1:0] nxt;
      pay = PAY_W'({IMG_MARK, a, a});
      nxt = a + UADDR_W'(1);
      return {pay, {CSEL_W{1'b0}}, nxt, NXT_INC};
   endfunction

   logic [CNT_W-1:0] cnt_q;
   logic             busy_q;
   logic             in_cs;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q  <= '0;
         busy_q <= 1'b1;
      end else if (busy_q) begin
         if (cnt_q == CNT_W'(TOTAL - 1)) busy_q <= 1'b0;
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   assign in_cs     = cnt_q < CNT_W'(CS_DEPTH);
   assign busy_o    = busy_q;
   assign cs_we_o   = busy_q && in_cs;
   assign cs_addr_o = cnt_q[UADDR_W-1:0];
   assign cs_data_o = image_word(cnt_q[UADDR_W-1:0]);
   assign dt_we_o   = busy_q && !in_cs;
   // CS_DEPTH is a power of two, so the low bits are the table offset
   assign dt_addr_o = cnt_q[OPC_W-1:0];
   assign dt_data_o = UADDR_W'({cnt_q[OPC_W-1:0], 2'b00});

   AST_LOAD_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cs_we_o |-> !dt_we_o)) else $error("store and table written together"); // R1

endmodule

// File: rtl/wcs_next_addr.sv
module wcs_next_addr
   import wcs_pkg::*;
#(
   parameter int UADDR_W = 10,
   parameter int CSEL_W  = 3
) (
   input  logic [UADDR_W-1:0]      pc_i,
   input  nxt_sel_e                sel_i,
   input  logic [UADDR_W-1:0]      target_i,
   input  logic [CSEL_W-1:0]       csel_i,
   input  logic [(1<<CSEL_W)-1:0]  cond_i,
   input  logic [UADDR_W-1:0]      disp_i,
   output logic [UADDR_W-1:0]      next_o
);
   logic [UADDR_W-1:0] inc;
   logic               cond_hit;

   assign inc      = pc_i + UADDR_W'(1);
   assign cond_hit = cond_i[csel_i];

   always_comb begin
      unique case (sel_i)
         NXT_INC:  next_o = inc;
         NXT_JMP:  next_o = target_i;
         NXT_CJMP: next_o = cond_hit ? target_i : inc;
         NXT_DISP: next_o = disp_i;
         default:  next_o = inc;
      endcase
   end

endmodule

// File: rtl/wcs_sequencer.sv
module wcs_sequencer
   import wcs_pkg::*;
#(
   parameter int UADDR_W = 10,
   parameter int UWORD_W = 48,
   parameter int OPC_W   = 8,
   parameter int CSEL_W  = 3
) (
   input  logic                     clk_i,
   input  logic                     rst_ni,
   input  logic [(1<<CSEL_W)-1:0]   cond_i,
   input  logic [OPC_W-1:0]         opcode_i,
   output logic [UWORD_W-1:0]       uinst_o,
   output logic [UADDR_W-1:0]       upc_o,
   output logic                     uvalid_o,
   output logic                     load_done_o,
   input  logic                     dbg_halt_req_i,
   input  logic                     dbg_step_i,
   input  logic                     dbg_resume_i,
   output logic                     dbg_halted_o,
   input  logic                     dbg_wr_i,
   input  logic                     dbg_wr_sel_i,
   input  logic [UADDR_W-1:0]       dbg_wr_addr_i,
   input  logic [UWORD_W-1:0]       dbg_wr_data_i,
   output logic                     dbg_wr_err_o
);
   localparam int FIELD_W  = SEL_W + UADDR_W + CSEL_W;
   localparam int TGT_LO   = SEL_W;
   localparam int CSEL_LO  = SEL_W + UADDR_W;

   if (UWORD_W <= FIELD_W) begin : g_bad_word
      $error("wcs_sequencer: UWORD_W must exceed the sequencing fields");
   end

   // boot loader
   logic               ld_busy;
   logic               ld_cs_we, ld_dt_we;
   logic [UADDR_W-1:0] ld_cs_addr, ld_dt_data;
   logic [UWORD_W-1:0] ld_cs_data;
   logic [OPC_W-1:0]   ld_dt_addr;

   wcs_boot_loader #(
      .UADDR_W(UADDR_W), .UWORD_W(UWORD_W), .OPC_W(OPC_W), .CSEL_W(CSEL_W)
   ) loader_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .busy_o    (ld_busy),
      .cs_we_o   (ld_cs_we),
      .cs_addr_o (ld_cs_addr),
      .cs_data_o (ld_cs_data),
      .dt_we_o   (ld_dt_we),
      .dt_addr_o (ld_dt_addr),
      .dt_data_o (ld_dt_data)
   );

   // control state
   seq_state_e         state_q;
   logic [UADDR_W-1:0] upc_q;
   logic               wr_err_q;
   logic               halted;
   logic               exec;
   logic               dbg_acc;

   assign halted  = !ld_busy && (state_q == SEQ_HALT);
   assign exec    = !ld_busy &&
                    (((state_q == SEQ_RUN) && !dbg_halt_req_i) ||
                     ((state_q == SEQ_HALT) && dbg_step_i && !dbg_resume_i));
   assign dbg_acc = dbg_wr_i && halted;

   // write port muxing: loader owns both memories until it finishes
   logic               cs_we, dt_we;
   logic [UADDR_W-1:0] cs_waddr, dt_wdata;
   logic [UWORD_W-1:0] cs_wdata;
   logic [OPC_W-1:0]   dt_waddr;

   assign cs_we    = ld_busy ? ld_cs_we   : (dbg_acc && !dbg_wr_sel_i);
   assign cs_waddr = ld_busy ? ld_cs_addr : dbg_wr_addr_i;
   assign cs_wdata = ld_busy ? ld_cs_data : dbg_wr_data_i;
   assign dt_we    = ld_busy ? ld_dt_we   : (dbg_acc && dbg_wr_sel_i);
   assign dt_waddr = ld_busy ? ld_dt_addr : dbg_wr_addr_i[OPC_W-1:0];
   assign dt_wdata = ld_busy ? ld_dt_data : dbg_wr_data_i[UADDR_W-1:0];

   logic [UWORD_W-1:0] cur_word;
   logic [UADDR_W-1:0] disp_entry;

   wcs_ram #(.ADDR_W(UADDR_W), .DATA_W(UWORD_W)) store_i (
      .clk_i   (clk_i),
      .we_i    (cs_we),
      .waddr_i (cs_waddr),
      .wdata_i (cs_wdata),
      .raddr_i (upc_q),
      .rdata_o (cur_word)
   );

   wcs_ram #(.ADDR_W(OPC_W), .DATA_W(UADDR_W)) dispatch_i (
      .clk_i   (clk_i),
      .we_i    (dt_we),
      .waddr_i (dt_waddr),
      .wdata_i (dt_wdata),
      .raddr_i (opcode_i),
      .rdata_o (disp_entry)
   );

   // field decode
   nxt_sel_e           f_sel;
   logic [UADDR_W-1:0] f_target;
   logic [CSEL_W-1:0]  f_csel;
   logic [UADDR_W-1:0] next_pc;

   assign f_sel    = nxt_sel_e'(cur_word[SEL_W-1:0]);
   assign f_target = cur_word[TGT_LO +: UADDR_W];
   assign f_csel   = cur_word[CSEL_LO +: CSEL_W];

   wcs_next_addr #(.UADDR_W(UADDR_W), .CSEL_W(CSEL_W)) next_i (
      .pc_i     (upc_q),
      .sel_i    (f_sel),
      .target_i (f_target),
      .csel_i   (f_csel),
      .cond_i   (cond_i),
      .disp_i   (disp_entry),
      .next_o   (next_pc)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q  <= SEQ_RUN;
         upc_q    <= '0;
         wr_err_q <= 1'b0;
      end else begin
         wr_err_q <= dbg_wr_i && !halted;
         if (exec) upc_q <= next_pc;
         if (!ld_busy) begin
            unique case (state_q)
               SEQ_RUN:  if (dbg_halt_req_i) state_q <= SEQ_HALT;
               SEQ_HALT: if (dbg_resume_i)   state_q <= SEQ_RUN;
               default:  state_q <= SEQ_RUN;
            endcase
         end
      end
   end

   assign uinst_o      = cur_word;
   assign upc_o        = upc_q;
   assign uvalid_o     = exec;
   assign load_done_o  = !ld_busy;
   assign dbg_halted_o = halted;
   assign dbg_wr_err_o = wr_err_q;

   // checks on the sequencing and debug control
   AST_NO_RUN_IN_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!load_done_o |-> !uvalid_o)) else $error("execution during boot copy"); // R1

   AST_SEQ_STEP_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((exec && f_sel == NXT_INC) |=> (upc_q == $past(upc_q) + UADDR_W'(1))))
      else $error("sequential advance wrong"); // R3

   AST_JUMP_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((exec && f_sel == NXT_JMP) |=> (upc_q == $past(f_target))))
      else $error("jump target missed"); // R4

   AST_HALT_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((!ld_busy && state_q == SEQ_RUN && dbg_halt_req_i) |=> (dbg_halted_o && $stable(upc_q))))
      else $error("halt did not stop at boundary"); // R7

   AST_HALT_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((halted && !exec) |=> $stable(upc_q))) else $error("micro-PC moved while halted"); // R7

   AST_STEP_STAYS_HALTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((halted && exec) |=> dbg_halted_o)) else $error("step left halted state"); // R8

   AST_RESUME_RUNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((halted && dbg_resume_i) |=> !dbg_halted_o)) else $error("resume ignored"); // R9

   AST_REFUSE_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((dbg_wr_i && !halted) |=> dbg_wr_err_o)) else $error("refused write not flagged"); // R11

endmodule

// File: tb/wcs_sequencer_tb_top.sv
module wcs_sequencer_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  cond = '0;
   logic [7:0]  opcode = '0;
   logic [47:0] uinst;
   logic [9:0]  upc;
   logic        uvalid, load_done, halted, wr_err;
   logic        halt_req = 1'b0, step = 1'b0, resume = 1'b0;
   logic        wr = 1'b0, wr_sel = 1'b0;
   logic [9:0]  wr_addr = '0;
   logic [47:0] wr_data = '0;

   int total = 0;
   int bad   = 0;

   always #4 clk = ~clk; // 125 MHz

   wcs_sequencer dut_i (
      .clk_i(clk), .rst_ni(rst_n), .cond_i(cond), .opcode_i(opcode),
      .uinst_o(uinst), .upc_o(upc), .uvalid_o(uvalid), .load_done_o(load_done),
      .dbg_halt_req_i(halt_req), .dbg_step_i(step), .dbg_resume_i(resume),
      .dbg_halted_o(halted), .dbg_wr_i(wr), .dbg_wr_sel_i(wr_sel),
      .dbg_wr_addr_i(wr_addr), .dbg_wr_data_i(wr_data), .dbg_wr_err_o(wr_err)
   );

   // vector: sel(2) target(10) csel(3) cond(8) opcode(8) expected next(10)
   localparam int NVEC = 9;
   localparam logic [40:0] VEC [NVEC] = '{
      {2'b01, 10'h100, 3'd0, 8'h00, 8'h00, 10'h100}, // R4 jump
      {2'b10, 10'h200, 3'd3, 8'h08, 8'h00, 10'h200}, // R5 taken
      {2'b10, 10'h050, 3'd3, 8'hF7, 8'h00, 10'h201}, // R5 not taken
      {2'b00, 10'h000, 3'd0, 8'h00, 8'h00, 10'h202}, // R3 increment
      {2'b11, 10'h000, 3'd0, 8'h00, 8'h3C, 10'h2F0}, // R6 patched entry
      {2'b11, 10'h000, 3'd0, 8'h00, 8'h07, 10'h01C}, // R6 boot entry
      {2'b01, 10'h3FF, 3'd0, 8'h00, 8'h00, 10'h3FF}, // R4 top of store
      {2'b00, 10'h000, 3'd0, 8'h00, 8'h00, 10'h000}, // R3 wrap
      {2'b10, 10'h123, 3'd7, 8'h80, 8'h00, 10'h123}  // R5 highest bit
   };

   function automatic logic [47:0] img(input logic [9:0] a);
      return {13'h1A5, a, a, 3'b000, a + 10'd1, 2'b00};
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [9:0]  pc;
      logic [47:0] w;
      repeat (3) @(negedge clk);
      chk("R1 reset load_done", 64'(load_done), 64'd0);
      chk("R1 reset uvalid", 64'(uvalid), 64'd0);
      chk("R1 reset upc", 64'(upc), 64'd0);
      chk("R1 reset halted", 64'(halted), 64'd0);
      rst_n = 1'b1;
      for (int k = 0; k < 1279; k++) cyc();
      chk("R1 last load cycle done", 64'(load_done), 64'd0);
      chk("R1 last load cycle uvalid", 64'(uvalid), 64'd0);
      cyc();
      chk("R1 load complete", 64'(load_done), 64'd1);
      chk("R1 start upc", 64'(upc), 64'd0);
      chk("R1 running", 64'(uvalid), 64'd1);
      chk("R2 image word 0", 64'(uinst), 64'(img(10'd0)));
      repeat (5) cyc();
      chk("R3 sequential upc", 64'(upc), 64'd5);
      chk("R2 image word 5", 64'(uinst), 64'(img(10'd5)));

      halt_req = 1'b1;
      #1;
      chk("R7 no exec on halt request", 64'(uvalid), 64'd0);
      cyc();
      halt_req = 1'b0;
      chk("R7 halted", 64'(halted), 64'd1);
      chk("R7 upc kept", 64'(upc), 64'd5);
      repeat (3) cyc();
      chk("R7 upc frozen", 64'(upc), 64'd5);
      chk("R7 word frozen", 64'(uinst), 64'(img(10'd5)));

      wr = 1'b1; wr_sel = 1'b1; wr_addr = 10'h03C; wr_data = 48'h2F0;
      cyc();
      wr = 1'b0; wr_sel = 1'b0;
      chk("R10 table write no flag", 64'(wr_err), 64'd0);

      pc = 10'd5;
      for (int i = 0; i < NVEC; i++) begin
         w = {33'h0, VEC[i][28:26], VEC[i][38:29], VEC[i][40:39]};
         wr = 1'b1; wr_addr = pc; wr_data = w;
         cyc();
         wr = 1'b0;
         chk("R10 patch visible", 64'(uinst), 64'(w));
         cond = VEC[i][25:18]; opcode = VEC[i][17:10]; step = 1'b1;
         #1;
         chk("R8 step executes", 64'(uvalid), 64'd1);
         cyc();
         step = 1'b0;
         chk("R3 R4 R5 R6 next address", 64'(upc), 64'(VEC[i][9:0]));
         chk("R8 still halted", 64'(halted), 64'd1);
         pc = VEC[i][9:0];
      end

      resume = 1'b1; step = 1'b1;
      #1;
      chk("R9 resume beats step", 64'(uvalid), 64'd0);
      cyc();
      resume = 1'b0; step = 1'b0;
      chk("R9 running again", 64'(halted), 64'd0);
      chk("R9 upc at resume", 64'(upc), 64'h123);
      cyc();
      chk("R9 advancing", 64'(upc), 64'h124);

      wr = 1'b1; wr_addr = 10'h3A0; wr_data = '1;
      cyc();
      wr = 1'b0;
      chk("R11 refused flag", 64'(wr_err), 64'd1);
      cyc();
      chk("R11 flag clears", 64'(wr_err), 64'd0);
      halt_req = 1'b1;
      cyc();
      halt_req = 1'b0;
      chk("R7 halted again", 64'(upc), 64'h126);
      wr = 1'b1; wr_addr = 10'h126; wr_data = {33'h0, 3'd0, 10'h3A0, 2'b01};
      cyc();
      wr = 1'b0;
      step = 1'b1;
      cyc();
      step = 1'b0;
      chk("R11 jump to refused address", 64'(upc), 64'h3A0);
      chk("R11 word unchanged", 64'(uinst), 64'(img(10'h3A0)));

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule